// File: doc/BRIEF.md
# Two-Level Chip-Select Decoder for an External Memory Map

This block turns a 16-bit byte address and an address-valid strobe into active-low chip selects for a fixed set of external devices. The devices are a 16 KB RAM, two ROMs, and two small peripherals: an ADC and an LCD. The decoding runs in two stages. The first stage splits the address space into eight 8 KB blocks using the three most significant address bits. Two adjacent 8 KB outputs are joined by a negative-logic OR to form the RAM's 16 KB region. A third first-stage output enables a second 3-to-8 stage. That stage uses the next three address bits to divide its 8 KB block into 1 KB slots, one slot for each small device.

The block leaves the address bits below each device's window undecoded. As a result, the 4 KB ROM appears twice in its 8 KB block, and the ADC and LCD registers repeat throughout their 1 KB slots. On-chip regions are never treated as external, so no device select asserts there. A separate flag reports any valid access to external space that no device claims. A parameter picks the output timing: combinational, or registered on the system clock with one cycle of latency.

Top module: `memmap_cs_decoder`

## Requirements
- R1: While `addrValid` is low, every select output is high (inactive) and `unmapped` is low.
- R2: `ramSelN` is low for every valid address in 0x4000–0x7FFF, and for no other address.
- R3: `rom1SelN` is low for every valid address in 0x2000–0x3FFF, and for no other address. The 4 KB ROM therefore appears twice in this block.
- R4: `rom2SelN` is low for every valid address in 0x8000–0x83FF, and for no other address.
- R5: `adcSelN` is low for every valid address in 0x8400–0x87FF, and for no other address. The ADC's four registers therefore repeat throughout this slot.
- R6: `lcdSelN` is low for every valid address in 0x8800–0x8BFF, and for no other address.
- R7: For a valid address in an on-chip region (0x0000–0x00FF, 0x1000–0x103F, 0xB600–0xB7FF, 0xE000–0xFFFF), all selects stay high and `unmapped` stays low.
- R8: At most one select output is low at any time.
- R9: `unmapped` is high exactly when `addrValid` is high, the address is in no on-chip region, and no select is low.
- R10: With `REG_OUT`=1, the outputs show the inputs that were present at the previous rising clock edge. While `rstN` is low, all selects are high and `unmapped` is low.
- R11: With `REG_OUT`=0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; used only when REG_OUT=1 |
| rstN | input | 1 | Asynchronous active-low reset for the output register |
| addr | input | 16 | Byte address |
| addrValid | input | 1 | High when addr holds a valid bus address |
| ramSelN | output | 1 | Active-low RAM select |
| rom1SelN | output | 1 | Active-low select for the 4 KB ROM |
| rom2SelN | output | 1 | Active-low select for the 1 KB ROM |
| adcSelN | output | 1 | Active-low ADC select |
| lcdSelN | output | 1 | Active-low LCD select |
| unmapped | output | 1 | High for a valid external access that no device claims |

## Verification
The bench first drives selected addresses at each device's first and last byte, at the edges of every on-chip region, and at alias points such as 0x3000 and 0x87FC. These probes separate off-by-one range errors from wrong bit selection. It then sweeps all 65,536 addresses with the strobe high. The sweep catches any address where two selects overlap, where a select leaks into an on-chip region, or where the unmapped flag is wrong. A strided sweep with the strobe low shows that the strobe gates every output. The combinational and registered variants run side by side on the same stimulus. Each registered output is compared both against the previous item and against the current one, which distinguishes correct one-cycle latency from zero or two cycles.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W   = 16;
  localparam int STAGE_W  = 3;
  localparam int TOP_LSB  = ADDR_W - STAGE_W;
  localparam int SUB_LSB  = TOP_LSB - STAGE_W;
  localparam int STAGE_N  = 1 << STAGE_W;

  // first-stage block numbers
  localparam int LOWINT_BLK  = 0;
  localparam int ROM1_BLK    = 1;
  localparam int RAM_BLK_A   = 2;
  localparam int RAM_BLK_B   = 3;
  localparam int SUB_BLK     = 4;
  localparam int EEP_BLK     = 5;
  localparam int TOPINT_BLK  = 7;

  // second-stage slot numbers
  localparam int ROM2_SLOT = 0;
  localparam int ADC_SLOT  = 1;
  localparam int LCD_SLOT  = 2;

  typedef struct packed {
    logic access;
    logic internalHit;
    logic ram;
    logic rom1;
    logic rom2;
    logic adc;
    logic lcd;
  } selStrobe_t;
endpackage

// File: rtl/memmap_dec3to8.sv
module memmap_dec3to8 #(
  parameter int SEL_W = 3,
  localparam int OUT_N = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] code,
  output logic [OUT_N-1:0] yN
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_out
    assign yN[i] = ~(en && (code == SEL_W'(i)));
  end
endmodule

// File: rtl/memmap_sel_ctrl.sv
module memmap_sel_ctrl
  import memmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrValid,
  output selStrobe_t        strobes
);
  logic [STAGE_N-1:0] blkN;
  logic [STAGE_N-1:0] subN;
  logic lowPageHit, regWinHit, eepHit;
  logic unusedLowBits;
  logic unusedSpareSlots;

  memmap_dec3to8 #(.SEL_W(STAGE_W)) u_stageTop (
    .en   (addrValid),
    .code (addr[ADDR_W-1:TOP_LSB]),
    .yN   (blkN)
  );

  memmap_dec3to8 #(.SEL_W(STAGE_W)) u_stageSub (
    .en   (~blkN[SUB_BLK]),
    .code (addr[TOP_LSB-1:SUB_LSB]),
    .yN   (subN)
  );

  // on-chip windows inside their 8 KB blocks
  assign lowPageHit = (addr[TOP_LSB-1:8] == '0);
  assign regWinHit  = (addr[TOP_LSB-1:6] == 7'b1000000);
  assign eepHit     = (addr[TOP_LSB-1:9] == 4'b1011);

  assign unusedLowBits    = ^addr[5:0];
  assign unusedSpareSlots = &subN;

  always_comb begin
    strobes.access      = addrValid;
    strobes.internalHit = ~blkN[TOPINT_BLK]
                        | (~blkN[LOWINT_BLK] & (lowPageHit | regWinHit))
                        | (~blkN[EEP_BLK] & eepHit);
    // negative-logic OR of two 8 KB selects
    strobes.ram  = ~(blkN[RAM_BLK_A] & blkN[RAM_BLK_B]);
    strobes.rom1 = ~blkN[ROM1_BLK];
    strobes.rom2 = ~subN[ROM2_SLOT];
    strobes.adc  = ~subN[ADC_SLOT];
    strobes.lcd  = ~subN[LCD_SLOT];
  end
endmodule

// File: rtl/memmap_out_dp.sv
module memmap_out_dp
  import memmap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  localparam int SEL_N = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStrobe_t       strobes,
  output logic [SEL_N-1:0] selN,
  output logic             unmapped
);
  logic [SEL_N-1:0] selNNext;
  logic             unmNext;
  logic             anyDev;

  assign anyDev   = strobes.ram | strobes.rom1 | strobes.rom2 | strobes.adc | strobes.lcd;
  assign selNNext = ~{strobes.ram, strobes.rom1, strobes.rom2, strobes.adc, strobes.lcd};
  assign unmNext  = strobes.access & ~strobes.internalHit & ~anyDev;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selN     <= '1;
        unmapped <= 1'b0;
      end else begin
        selN     <= selNNext;
        unmapped <= unmNext;
      end
    end
  end else begin : g_comb
    assign selN     = selNNext;
    assign unmapped = unmNext;
  end
endmodule

// File: rtl/memmap_cs_decoder.sv
module memmap_cs_decoder
  import memmap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrValid,
  output logic              ramSelN,
  output logic              rom1SelN,
  output logic              rom2SelN,
  output logic              adcSelN,
  output logic              lcdSelN,
  output logic              unmapped
);
  selStrobe_t strobes;
  logic [4:0] selN;

  memmap_sel_ctrl u_ctrl (
    .addr      (addr),
    .addrValid (addrValid),
    .strobes   (strobes)
  );

  memmap_out_dp #(.REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .selN     (selN),
    .unmapped (unmapped)
  );

  assign {ramSelN, rom1SelN, rom2SelN, adcSelN, lcdSelN} = selN;
endmodule

// File: rtl/memmap_cs_checker.sv
module memmap_cs_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic        addrValid,
  input logic        ramSelN,
  input logic        rom1SelN,
  input logic        rom2SelN,
  input logic        adcSelN,
  input logic        lcdSelN,
  input logic        unmapped
);
  logic [15:0] chkAddr;
  logic        chkValid;
  logic [4:0]  sels;
  logic        inInternal;

  if (REG_OUT) begin : g_delay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chkAddr  <= '0;
        chkValid <= 1'b0;
      end else begin
        chkAddr  <= addr;
        chkValid <= addrValid;
      end
    end
  end else begin : g_same
    assign chkAddr  = addr;
    assign chkValid = addrValid;
  end

  assign sels = {ramSelN, rom1SelN, rom2SelN, adcSelN, lcdSelN};
  assign inInternal = (chkAddr inside {[16'h0000:16'h00FF], [16'h1000:16'h103F],
                                       [16'hB600:16'hB7FF], [16'hE000:16'hFFFF]});

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> (sels == 5'b11111) && !unmapped);

  p_ram_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ramSelN |-> chkValid && (chkAddr inside {[16'h4000:16'h7FFF]}));

  p_rom1_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && (chkAddr inside {[16'h2000:16'h3FFF]})) |-> !rom1SelN);

  p_adc_r5: assert property (@(posedge clk) disable iff (!rstN)
    !adcSelN |-> chkValid && (chkAddr inside {[16'h8400:16'h87FF]}));

  p_lcd_r6: assert property (@(posedge clk) disable iff (!rstN)
    !lcdSelN |-> chkValid && (chkAddr inside {[16'h8800:16'h8BFF]}));

  p_internal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && inInternal) |-> (sels == 5'b11111) && !unmapped);

  p_one_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~sels) <= 1);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> chkValid && !inInternal && (sels == 5'b11111));
endmodule

bind memmap_cs_decoder memmap_cs_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .addrValid (addrValid),
  .ramSelN   (ramSelN),
  .rom1SelN  (rom1SelN),
  .rom2SelN  (rom2SelN),
  .adcSelN   (adcSelN),
  .lcdSelN   (lcdSelN),
  .unmapped  (unmapped)
);

// File: tb/test_memmap_cs_decoder.sv
module test_memmap_cs_decoder;
  typedef struct {
    logic [15:0] a;
    logic        v;
    logic [5:0]  exp;   // {ram,rom1,rom2,adc,lcd selects (active low), unmapped}
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        addrValid = 1'b0;
  logic ramR, rom1R, rom2R, adcR, lcdR, unmR;
  logic ramC, rom1C, rom2C, adcC, lcdC, unmC;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit driveDone = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;

  memmap_cs_decoder #(.REG_OUT(1'b1)) i_memmap_cs_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .addrValid(addrValid),
    .ramSelN(ramR), .rom1SelN(rom1R), .rom2SelN(rom2R),
    .adcSelN(adcR), .lcdSelN(lcdR), .unmapped(unmR));

  memmap_cs_decoder #(.REG_OUT(1'b0)) i_memmap_cs_decoder_comb (
    .clk(clk), .rstN(rstN), .addr(addr), .addrValid(addrValid),
    .ramSelN(ramC), .rom1SelN(rom1C), .rom2SelN(rom2C),
    .adcSelN(adcC), .lcdSelN(lcdC), .unmapped(unmC));

  function automatic logic [5:0] model(logic [15:0] a, logic v);
    logic ram, rom1, rom2, adc, lcd, intl, unm;
    ram  = v && a >= 16'h4000 && a <= 16'h7FFF;
    rom1 = v && a >= 16'h2000 && a <= 16'h3FFF;
    rom2 = v && a >= 16'h8000 && a <= 16'h83FF;
    adc  = v && a >= 16'h8400 && a <= 16'h87FF;
    lcd  = v && a >= 16'h8800 && a <= 16'h8BFF;
    intl = a <= 16'h00FF || (a >= 16'h1000 && a <= 16'h103F) ||
           (a >= 16'hB600 && a <= 16'hB7FF) || a >= 16'hE000;
    unm  = v && !intl && !(ram || rom1 || rom2 || adc || lcd);
    return {~ram, ~rom1, ~rom2, ~adc, ~lcd, unm};
  endfunction

  function automatic string reqOf(logic [15:0] a, logic v);
    if (!v) return "R1";
    if (a >= 16'h4000 && a <= 16'h7FFF) return "R2";
    if (a >= 16'h2000 && a <= 16'h3FFF) return "R3";
    if (a >= 16'h8000 && a <= 16'h83FF) return "R4";
    if (a >= 16'h8400 && a <= 16'h87FF) return "R5";
    if (a >= 16'h8800 && a <= 16'h8BFF) return "R6";
    if (a <= 16'h00FF || (a >= 16'h1000 && a <= 16'h103F) ||
        (a >= 16'hB600 && a <= 16'hB7FF) || a >= 16'hE000) return "R7";
    return "R9";
  endfunction

  task automatic check(string req, string what, logic [5:0] act, logic [5:0] exp, logic [15:0] a);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s addr=%h actual=%b expected=%b", req, what, a, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] a, logic v);
    item_t it;
    @(negedge clk);
    addr = a;
    addrValid = v;
    it.a = a; it.v = v; it.exp = model(a, v);
    q.push_back(it);
  endtask

  // monitor: comb same cycle (R11); registered one edge later (R10)
  initial begin
    item_t prev, cur;
    bit havePrev = 1'b0;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        cur = q[0];
        check({reqOf(cur.a, cur.v), "/R11"}, "comb",
              {ramC, rom1C, rom2C, adcC, lcdC, unmC}, cur.exp, cur.a);
        checks++;  // R8: one-hot-or-none on the comb variant
        if ($countones(~{ramC, rom1C, rom2C, adcC, lcdC}) > 1) begin
          fails++;
          $display("FAIL R8 multiple selects addr=%h actual=%b expected=at most one low",
                   cur.a, {ramC, rom1C, rom2C, adcC, lcdC});
        end
        if (havePrev)
          check("R10", "reg before edge", {ramR, rom1R, rom2R, adcR, lcdR, unmR},
                prev.exp, prev.a);
        @(posedge clk);
        #5;
        check({reqOf(cur.a, cur.v), "/R10"}, "reg after edge",
              {ramR, rom1R, rom2R, adcR, lcdR, unmR}, cur.exp, cur.a);
        prev = cur;
        havePrev = 1'b1;
        void'(q.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset holds registered outputs inactive even with a RAM address applied
    @(negedge clk);
    addr = 16'h4000;
    addrValid = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check("R10", "reset state", {ramR, rom1R, rom2R, adcR, lcdR, unmR}, 6'b111110, addr);
    check("R11", "comb during reset", {ramC, rom1C, rom2C, adcC, lcdC, unmC}, 6'b011110, addr);
    @(negedge clk);
    addrValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // directed corners
    drive(16'h4000, 1'b1); drive(16'h7FFF, 1'b1); drive(16'h3FFF, 1'b0);   // R2, R1
    drive(16'h8000, 1'b0);                                                  // R1
    drive(16'h2000, 1'b1); drive(16'h3000, 1'b1); drive(16'h1FFF, 1'b1);   // R3 alias, R9
    drive(16'h8000, 1'b1); drive(16'h83FF, 1'b1);                           // R4
    drive(16'h8400, 1'b1); drive(16'h87FC, 1'b1); drive(16'h8401, 1'b1);   // R5 alias
    drive(16'h8800, 1'b1); drive(16'h8BFF, 1'b1); drive(16'h8C00, 1'b1);   // R6, R9
    drive(16'h00FF, 1'b1); drive(16'h0100, 1'b1); drive(16'h103F, 1'b1);   // R7, R9
    drive(16'h1040, 1'b1); drive(16'hB5FF, 1'b1); drive(16'hB600, 1'b1);   // R9, R7
    drive(16'hB7FF, 1'b1); drive(16'hB800, 1'b1); drive(16'hDFFF, 1'b1);   // R7, R9
    drive(16'hE000, 1'b1); drive(16'hFFFF, 1'b1);                          // R7

    // full sweep, strobe high: R2..R9
    for (int i = 0; i < 65536; i++) drive(16'(i), 1'b1);
    // strided sweep, strobe low: R1
    for (int i = 0; i < 65536; i += 97) drive(16'(i), 1'b0);

    driveDone = 1'b1;
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule